// File: doc/BRIEF.md
# Configurable Eight-Pin I/O Port

This block is a general-purpose I/O port with a parameterised number of pins (eight by default). Software reaches three registers over a small synchronous register bus: a data latch, a direction register and an option register. It also has one write-only address that clears the pending interrupt. On the pad side, each pin receives the level seen on the pad and drives an output value, an output enable and a pull-up enable.

The meaning of a pin's option bit depends on its direction. On an output pin it selects push-pull or open-drain drive. On an input pin it selects a floating input or a pull-up input that can raise an interrupt. A falling edge on such a pull-up input sets a sticky pending flag. That flag drives the interrupt request and the wake request for the low-power sequencer, unless the global interrupt mask input is set.

Top module: `gpio_port`

## Requirements
- R1: After reset, the data, direction and option registers read 00h, every output enable and pull-up enable is low, and the interrupt and wake requests are low.
- R2: Register addresses are 0 = data, 1 = direction, 2 = option and 3 = pending clear (write only, reads as 00h). The direction and option registers read back the last value written to them.
- R3: A write to the data register always updates the latch, including for input pins. When a pin is later switched to push-pull output, its pad output shows the latched bit.
- R4: Reading address 0 returns, bit by bit, the latch bit for pins whose direction bit is 1 (output) and the pad level for pins whose direction bit is 0 (input). The pad level goes through two synchronizer flops, so a pad change is visible on the read after the second rising clock edge.
- R5: An output pin with option bit 1 (push-pull) has its output enable high and its pad output equal to the latch bit.
- R6: An output pin with option bit 0 (open-drain) drives 0 with its output enable high when the latch bit is 0. It releases the output enable when the latch bit is 1, and its pad output is always 0.
- R7: Pull-up enable is high exactly for input pins (direction 0) whose option bit is 1. Input pins never have their output enable high.
- R8: A falling edge on the synchronized level of a pull-up input pin (direction 0, option 1) sets the pending flag on the third rising edge after the pad falls. A rising edge does not set it. Neither does a falling edge on a floating input or on an output pin.
- R9: The pending flag stays set until a write to address 3. If a new event and a clear meet in the same cycle, the flag stays set.
- R10: The interrupt request and the wake request are both high when the pending flag is set and the interrupt mask input is low. Events that arrive while the mask is high are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data (combinational from address) |
| intMask | input | 1 | Global interrupt mask, 1 blocks requests |
| padIn | input | 8 | Level seen on each pad |
| padOut | output | 8 | Value driven to each pad |
| padOe | output | 8 | Output enable per pad |
| padPullUp | output | 8 | Pull-up enable per pad |
| irqReq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Wake request to the low-power sequencer |

## Verification
A wrong direction or option bit shows at once on the pad enables and on the read value, in the same cycle as the bad bit. A wrong latch bit shows as soon as its pin becomes an output. A fault in the synchronizer or the edge detector moves the interrupt away from its place exactly three edges after the pad falls, or raises it for a configuration that must stay quiet. The bench runs that check for every pin and for every direction and option pair. A pending flag that decays, or that ignores a clear, shows on the request outputs within one cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_DIR  = 2'd1,
    ADDR_OPT  = 2'd2,
    ADDR_CLR  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic       wrData;
    logic       wrDir;
    logic       wrOpt;
    logic       clrPend;
    logic [1:0] rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWe,
  input  logic [1:0]   regAddr,
  input  logic         intMask,
  input  logic         anyEvent,
  output ctrlStrobes_t ctl,
  output logic         irqReq,
  output logic         wakeReq
);
  logic pendQ;

  always_comb begin
    ctl.wrData  = regWe && (regAddr == ADDR_DATA);
    ctl.wrDir   = regWe && (regAddr == ADDR_DIR);
    ctl.wrOpt   = regWe && (regAddr == ADDR_OPT);
    ctl.clrPend = regWe && (regAddr == ADDR_CLR);
    ctl.rdSel   = regAddr;
  end

  // new event has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pendQ <= 1'b0;
    else if (anyEvent)     pendQ <= 1'b1;
    else if (ctl.clrPend)  pendQ <= 1'b0;
  end

  assign irqReq  = pendQ && !intMask;
  assign wakeReq = pendQ && !intMask;

  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !ctl.clrPend) |=> pendQ);
  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrPend && !anyEvent) |=> !pendQ);
  assert_event_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyEvent |=> pendQ);
  assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> (!irqReq && !wakeReq));
endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t ctl,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] padPullUp,
  output logic [W-1:0] rdData,
  output logic         anyEvent
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [W-1:0] dataQ, dirQ, optQ, prevQ;
  logic [SYNC_STAGES-1:0][W-1:0] syncQ;
  logic [W-1:0] pinLvl, fallHit, pinRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      optQ  <= '0;
    end else begin
      if (ctl.wrData) dataQ <= wrData;
      if (ctl.wrDir)  dirQ  <= wrData;
      if (ctl.wrOpt)  optQ  <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign pinLvl = syncQ[LAST];

  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (dirQ[p]) begin
        padOut[p]    = optQ[p] & dataQ[p];
        padOe[p]     = optQ[p] | ~dataQ[p];
        padPullUp[p] = 1'b0;
      end else begin
        padOut[p]    = 1'b0;
        padOe[p]     = 1'b0;
        padPullUp[p] = optQ[p];
      end
      pinRd[p]   = dirQ[p] ? dataQ[p] : pinLvl[p];
      fallHit[p] = ~dirQ[p] & optQ[p] & prevQ[p] & ~pinLvl[p];
    end
  end

  assign anyEvent = |fallHit;

  always_comb begin
    unique case (ctl.rdSel)
      ADDR_DATA: rdData = pinRd;
      ADDR_DIR:  rdData = dirQ;
      ADDR_OPT:  rdData = optQ;
      default:   rdData = '0;
    endcase
  end

  assert_latch_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrData |=> (dataQ == $past(wrData)));
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrDir |=> (dirQ == $past(wrData)));
  assert_no_pull_on_drive_R7: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padOe) == '0);
  assert_event_needs_pullup_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyEvent |-> ((padPullUp & ~pinLvl) != '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWe,
  input  logic [1:0]   regAddr,
  input  logic [W-1:0] regWdata,
  output logic [W-1:0] regRdata,
  input  logic         intMask,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padOe,
  output logic [W-1:0] padPullUp,
  output logic         irqReq,
  output logic         wakeReq
);
  ctrlStrobes_t ctl;
  logic anyEvent;

  gpio_port_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .intMask(intMask), .anyEvent(anyEvent), .ctl(ctl),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  gpio_port_dp #(.W(W), .SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(regWdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .rdData(regRdata), .anyEvent(anyEvent)
  );
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0, regWe = 0, intMask = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata, padIn = 0, padOut, padOe, padPullUp;
  logic irqReq, wakeReq;
  int nRun = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    regAddr = a; #1; d = regRdata;
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v, dir, opt, dat;
    edges(2); rstN = 1; edges(1);
    // R1 reset state
    rd(0, v); check("R1 data", v, 0);
    rd(1, v); check("R1 dir", v, 0);
    rd(2, v); check("R1 opt", v, 0);
    check("R1 oe", padOe, 0); check("R1 pull", padPullUp, 0);
    check("R1 irq", {irqReq, wakeReq}, 0);
    rd(3, v); check("R2 clr reads zero", v, 0);

    // R3 latch write while input, then switch to push-pull
    wr(0, 8'hA5); check("R3 input no drive", padOe, 0);
    wr(2, 8'hFF); wr(1, 8'hFF);
    check("R3 latch shows", padOut, 8'hA5); wr(1, 0); wr(2, 0);

    // configuration sweep: R2 R4 R5 R6 R7
    for (int c = 0; c < 64; c++) begin
      dir = 8'(c * 37 + 5); opt = 8'(c * 91 + 3); dat = 8'(c * 53 + 11);
      wr(1, dir); wr(2, opt); wr(0, dat);
      padIn = ~dat ^ 8'(c);
      edges(2);
      rd(1, v); check("R2 dir readback", v, dir);
      rd(2, v); check("R2 opt readback", v, opt);
      rd(0, v); check("R4 data read mix", v, (dir & dat) | (~dir & padIn));
      check("R5_R6 oe", padOe, dir & (opt | ~dat));
      check("R5_R6 out", padOut, dir & opt & dat);
      check("R7 pull", padPullUp, ~dir & opt);
    end

    // R4 synchronizer latency
    wr(1, 0); wr(2, 0); padIn = 0; edges(3);
    @(negedge clk); padIn = 8'h3C;
    edges(1); rd(0, v); check("R4 one edge not yet", v, 0);
    edges(1); rd(0, v); check("R4 two edges seen", v, 8'h3C);

    // R8 per-pin, per-configuration falling edge
    for (int p = 0; p < 8; p++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        padIn = 8'hFF;
        wr(1, cfg[1] ? 8'(1 << p) : 8'h00);
        wr(2, cfg[0] ? 8'(1 << p) : 8'h00);
        edges(3); wr(3, 0);
        check("R8 quiet before edge", irqReq, 0);
        @(negedge clk); padIn[p] = 0;
        edges(2); check("R8 not before third edge", irqReq, 0);
        edges(1);
        check("R8 falling edge event", irqReq, (cfg == 1) ? 1 : 0);
        padIn[p] = 1; edges(4); wr(3, 0);
      end
    end

    // R8 rising edge ignored; R9 sticky, clear; R10 mask
    wr(1, 0); wr(2, 8'h01); padIn = 0; edges(4); wr(3, 0);
    @(negedge clk); padIn[0] = 1; edges(4);
    check("R8 rising edge ignored", irqReq, 0);
    @(negedge clk); padIn[0] = 0; edges(3);
    check("R9 set", irqReq, 1); edges(10);
    check("R9 sticky", irqReq, 1);
    intMask = 1; #1; check("R10 masked", {irqReq, wakeReq}, 0);
    intMask = 0; #1; check("R10 wake", wakeReq, 1);
    wr(3, 0); check("R9 cleared", irqReq, 0);
    intMask = 1; padIn[0] = 1; edges(4);
    @(negedge clk); padIn[0] = 0; edges(4);
    check("R10 masked hidden", irqReq, 0);
    intMask = 0; #1; check("R10 recorded while masked", {irqReq, wakeReq}, 2'b11);
    wr(3, 0); padIn[0] = 1; edges(4);

    // R9 set beats simultaneous clear
    @(negedge clk); padIn[0] = 0;
    edges(2); regWe = 1; regAddr = 3;
    @(negedge clk); regWe = 0;
    check("R9 set wins over clear", irqReq, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule